// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Responder (128 x 8)

This block behaves as a small byte-wide serial EEPROM on a three-wire bus (chip select, serial clock, data in) with one data-out line. It is intended as a synthesizable target that a bus master under test can talk to. It oversamples the bus pins with the system clock, decodes each 10-bit instruction, and carries out reads, single-byte writes and erases, and whole-array erase and fill operations. All of these act on an internal array that can be mapped to block RAM.

Every modifying operation is gated by a write-enable latch. When it runs, it starts a program window whose length is set by a parameter in system clock cycles. During that window the data-out line reads low while chip select is high, so a master can poll for completion. A whole-array operation fills the array one location per cycle inside the same window.

Top module: `mw_eeprom_responder`

## Requirements
- R1: An instruction begins at the first 1 sampled on a rising serial clock while chip select is high; zeros before it are ignored. Two opcode bits then follow, then seven address bits, most significant first. The opcodes are 10 read, 01 write, 11 erase byte, and 00 extended. In the extended case, address bits [6:5] select: 11 enable writes, 00 disable writes, 10 erase all, 01 write all.
- R2: On a read, the most significant data bit appears on data out after the rising clock that carries the last address bit. Each later rising clock presents the next lower bit. The rising clock after the least significant bit returns data out to 1.
- R3: A write shifts in 8 data bits, most significant first. The byte is stored only after chip select falls.
- R4: An erase-byte instruction sets the addressed byte to 0xFF.
- R5: Once a modifying instruction is committed, data out reads 0 whenever chip select is high, for PROG_CYCLES system clocks. After that it reads 1.
- R6: Reset clears the write-enable latch. With the latch clear, write, erase, erase-all and write-all change no memory and start no program window.
- R7: The disable instruction clears the write-enable latch.
- R8: Erase-all sets every byte to 0xFF.
- R9: Write-all loads every byte with the 8 data bits shifted in after the instruction.
- R10: Any instruction started during a program window is ignored.
- R11: If chip select falls before a modifying instruction is complete, memory is not changed and no program window starts.
- R12: Data out is 1 while chip select is low, and 1 while idle with chip select high and no program window running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rst | input | 1 | Synchronous active-high reset |
| cs_i | input | 1 | Chip select, active high |
| sk_i | input | 1 | Serial clock from the master |
| di_i | input | 1 | Serial data from the master |
| do_o | output | 1 | Serial data / ready-busy to the master |

## Verification
The assertions assume that each serial clock phase lasts several system clocks, so that a read has loaded its first bit before the next rising edge. They also assume that chip select holds each level for at least two system clocks, and that PROG_CYCLES is larger than the array depth, so that the fill sweep ends inside the program window. The bench holds each serial clock phase for 12 system clocks and keeps chip select low for 36 clocks between instructions. It sets the program window to 400 cycles against a depth of 128.

// File: rtl/mwe_pkg.sv
package mwe_pkg;
  typedef enum logic [1:0] {
    OP_EXT   = 2'b00,
    OP_WRITE = 2'b01,
    OP_READ  = 2'b10,
    OP_ERASE = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    EX_DISABLE = 2'b00,
    EX_WRALL   = 2'b01,
    EX_ERALL   = 2'b10,
    EX_ENABLE  = 2'b11
  } ext_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMD,
    ST_RWAIT,
    ST_RSHIFT,
    ST_WDATA,
    ST_ARMED,
    ST_HOLD
  } st_e;
endpackage

// File: rtl/mwe_in_sync.sv
module mwe_in_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] pipe_q [STAGES];

  genvar g;
  for (g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe_q[0] <= '0;
        else     pipe_q[0] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe_q[g] <= '0;
        else     pipe_q[g] <= pipe_q[g-1];
      end
    end
  end

  assign q_o = pipe_q[STAGES-1];
endmodule

// File: rtl/mwe_mem.sv
module mwe_mem #(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we_i) cells[waddr_i] <= wdata_i;
    rdata_o <= cells[raddr_i];
  end
endmodule

// File: rtl/mwe_prog_ctrl.sv
module mwe_prog_ctrl #(
  parameter int unsigned PROG_CYCLES = 300000,
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic          bulk_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [DW-1:0] wdata_o
);
  localparam int CNT_W = $clog2(PROG_CYCLES + 1);
  localparam logic [AW-1:0] LAST_ADDR = AW'(DEPTH - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;
  logic             sweep_q;
  logic [AW-1:0]    sweep_addr_q;
  logic [DW-1:0]    sweep_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q        <= '0;
      busy_q       <= 1'b0;
      sweep_q      <= 1'b0;
      sweep_addr_q <= '0;
      sweep_data_q <= '0;
    end else begin
      if (start_i) begin
        busy_q <= 1'b1;
        cnt_q  <= CNT_W'(PROG_CYCLES - 1);
      end else if (busy_q) begin
        if (cnt_q == '0) busy_q <= 1'b0;
        else             cnt_q  <= cnt_q - 1'b1;
      end

      if (start_i && bulk_i) begin
        sweep_q      <= 1'b1;
        sweep_addr_q <= '0;
        sweep_data_q <= data_i;
      end else if (sweep_q) begin
        sweep_addr_q <= sweep_addr_q + 1'b1;
        if (sweep_addr_q == LAST_ADDR) sweep_q <= 1'b0;
      end
    end
  end

  assign busy_o  = busy_q;
  assign we_o    = (start_i && !bulk_i) || sweep_q;
  assign waddr_o = sweep_q ? sweep_addr_q : addr_i;
  assign wdata_o = sweep_q ? sweep_data_q : data_i;
endmodule

// File: rtl/mwe_cmd_fsm.sv
module mwe_cmd_fsm
  import mwe_pkg::*;
#(
  parameter int DEPTH = 128,
  parameter int DW    = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_i,
  input  logic          sk_rise_i,
  input  logic          di_i,
  input  logic          busy_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] fill_o,
  output logic          bulk_o,
  output logic          start_o,
  output logic          wen_o,
  output logic          do_o
);
  localparam int CMD_BITS = 2 + AW;
  localparam int CW       = $clog2(CMD_BITS + DW + 1);

  st_e                   st_q;
  logic [CW-1:0]         cnt_q;
  logic [CMD_BITS-2:0]   sh_q;
  logic [DW-1:0]         dsr_q;
  logic [AW-1:0]         addr_q;
  logic [DW-1:0]         fill_q;
  logic                  bulk_q;
  logic                  wen_q;
  logic                  rwait_q;
  logic                  dout_q;
  logic                  do_q;
  logic                  start_q;

  logic [CMD_BITS-1:0]   full;
  op_e                   op;
  logic [AW-1:0]         a_new;
  ext_e                  ext;
  logic [DW-1:0]         wbyte;

  assign full  = {sh_q, di_i};
  assign op    = op_e'(full[CMD_BITS-1 -: 2]);
  assign a_new = full[AW-1:0];
  assign ext   = ext_e'(a_new[AW-1 -: 2]);
  assign wbyte = {dsr_q[DW-2:0], di_i};

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_IDLE;
      cnt_q   <= '0;
      sh_q    <= '0;
      dsr_q   <= '0;
      addr_q  <= '0;
      fill_q  <= '1;
      bulk_q  <= 1'b0;
      wen_q   <= 1'b0;
      rwait_q <= 1'b0;
      dout_q  <= 1'b1;
      do_q    <= 1'b1;
      start_q <= 1'b0;
    end else begin
      start_q <= 1'b0;
      do_q    <= !cs_i ? 1'b1 : (busy_i ? 1'b0 : dout_q);

      if (!cs_i) begin
        if (st_q == ST_ARMED && wen_q) start_q <= 1'b1;
        st_q   <= ST_IDLE;
        dout_q <= 1'b1;
      end else begin
        case (st_q)
          ST_IDLE: begin
            if (sk_rise_i && di_i && !busy_i) begin
              st_q  <= ST_CMD;
              cnt_q <= '0;
            end
          end
          ST_CMD: begin
            if (sk_rise_i) begin
              sh_q  <= full[CMD_BITS-2:0];
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CW'(CMD_BITS - 1)) begin
                addr_q  <= a_new;
                cnt_q   <= '0;
                bulk_q  <= 1'b0;
                fill_q  <= '1;
                rwait_q <= 1'b0;
                case (op)
                  OP_READ:  st_q <= ST_RWAIT;
                  OP_WRITE: st_q <= ST_WDATA;
                  OP_ERASE: st_q <= ST_ARMED;
                  default: begin
                    case (ext)
                      EX_ENABLE:  begin wen_q <= 1'b1; st_q <= ST_HOLD; end
                      EX_DISABLE: begin wen_q <= 1'b0; st_q <= ST_HOLD; end
                      EX_ERALL:   begin bulk_q <= 1'b1; st_q <= ST_ARMED; end
                      default:    begin bulk_q <= 1'b1; st_q <= ST_WDATA; end
                    endcase
                  end
                endcase
              end
            end
          end
          ST_RWAIT: begin
            rwait_q <= 1'b1;
            if (rwait_q) begin
              dsr_q  <= rdata_i;
              dout_q <= rdata_i[DW-1];
              cnt_q  <= '0;
              st_q   <= ST_RSHIFT;
            end
          end
          ST_RSHIFT: begin
            if (sk_rise_i) begin
              if (cnt_q == CW'(DW - 1)) begin
                dout_q <= 1'b1;
                st_q   <= ST_HOLD;
              end else begin
                dout_q <= dsr_q[DW-2];
                dsr_q  <= {dsr_q[DW-2:0], 1'b0};
                cnt_q  <= cnt_q + 1'b1;
              end
            end
          end
          ST_WDATA: begin
            if (sk_rise_i) begin
              dsr_q <= wbyte;
              cnt_q <= cnt_q + 1'b1;
              if (cnt_q == CW'(DW - 1)) begin
                fill_q <= wbyte;
                st_q   <= ST_ARMED;
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign addr_o  = addr_q;
  assign fill_o  = fill_q;
  assign bulk_o  = bulk_q;
  assign start_o = start_q;
  assign wen_o   = wen_q;
  assign do_o    = do_q;
endmodule

// File: rtl/mw_eeprom_responder.sv
module mw_eeprom_responder #(
  parameter int unsigned PROG_CYCLES = 300000,
  parameter int DEPTH       = 128,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic cs_i,
  input  logic sk_i,
  input  logic di_i,
  output logic do_o
);
  localparam int AW = $clog2(DEPTH);

  logic [2:0]    sync_q;
  logic          cs_s, sk_s, di_s;
  logic          sk_prev_q;
  logic          sk_rise;
  logic          busy;
  logic          start;
  logic          bulk;
  logic          wen;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] fill;
  logic [DW-1:0] rdata;
  logic          mem_we;
  logic [AW-1:0] mem_waddr;
  logic [DW-1:0] mem_wdata;

  mwe_in_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d_i ({cs_i, sk_i, di_i}),
    .q_o (sync_q)
  );

  assign {cs_s, sk_s, di_s} = sync_q;

  always_ff @(posedge clk) begin
    if (rst) sk_prev_q <= 1'b0;
    else     sk_prev_q <= sk_s;
  end

  assign sk_rise = sk_s && !sk_prev_q;

  mwe_cmd_fsm #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .cs_i      (cs_s),
    .sk_rise_i (sk_rise),
    .di_i      (di_s),
    .busy_i    (busy),
    .rdata_i   (rdata),
    .addr_o    (cmd_addr),
    .fill_o    (fill),
    .bulk_o    (bulk),
    .start_o   (start),
    .wen_o     (wen),
    .do_o      (do_o)
  );

  mwe_prog_ctrl #(.PROG_CYCLES(PROG_CYCLES), .DEPTH(DEPTH), .DW(DW), .AW(AW)) u_prog (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .bulk_i  (bulk),
    .addr_i  (cmd_addr),
    .data_i  (fill),
    .busy_o  (busy),
    .we_o    (mem_we),
    .waddr_o (mem_waddr),
    .wdata_o (mem_wdata)
  );

  mwe_mem #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_mem (
    .clk     (clk),
    .we_i    (mem_we),
    .waddr_i (mem_waddr),
    .wdata_i (mem_wdata),
    .raddr_i (cmd_addr),
    .rdata_o (rdata)
  );
endmodule

// File: rtl/mwe_checker.sv
module mwe_checker (
  input logic clk,
  input logic rst,
  input logic cs_s,
  input logic busy,
  input logic do_o,
  input logic mem_we,
  input logic wen,
  input logic start
);
  AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (rst)
    (busy && cs_s) |=> !do_o); // R5

  AST_DESELECT_HIGH: assert property (@(posedge clk) disable iff (rst)
    !cs_s |=> do_o); // R12

  AST_WRITE_NEEDS_WEN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> wen); // R6

  AST_WRITE_IN_WINDOW: assert property (@(posedge clk) disable iff (rst)
    mem_we |=> busy); // R5

  AST_COMMIT_AFTER_DESELECT: assert property (@(posedge clk) disable iff (rst)
    start |-> !cs_s); // R3

  AST_NO_COMMIT_WHILE_BUSY: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy); // R10
endmodule

bind mw_eeprom_responder mwe_checker u_chk (
  .clk    (clk),
  .rst    (rst),
  .cs_s   (cs_s),
  .busy   (busy),
  .do_o   (do_o),
  .mem_we (mem_we),
  .wen    (wen),
  .start  (start)
);

// File: tb/mw_eeprom_responder_tb.sv
module mw_eeprom_responder_tb;
  localparam int PROG = 400;
  localparam int HALF = 12;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cs  = 1'b0;
  logic sk  = 1'b0;
  logic di  = 1'b0;
  logic do_w;
  int   n_cmp  = 0;
  int   n_fail = 0;

  always #10 clk = ~clk;

  mw_eeprom_responder #(.PROG_CYCLES(PROG)) u_dut (
    .clk  (clk),
    .rst  (rst),
    .cs_i (cs),
    .sk_i (sk),
    .di_i (di),
    .do_o (do_w)
  );

  task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_out(input logic b, output logic s);
    di = b;
    sk = 1'b0;
    wait_clk(HALF);
    sk = 1'b1;
    wait_clk(HALF);
    s  = do_w;
    sk = 1'b0;
  endtask

  task automatic gap();
    cs = 1'b0;
    di = 1'b0;
    wait_clk(3 * HALF);
  endtask

  function automatic logic [9:0] mk(input logic [1:0] op, input logic [6:0] a);
    return {1'b1, op, a};
  endfunction

  task automatic instr(input logic [9:0] cmd, input bit has_data, input logic [7:0] data);
    logic s;
    cs = 1'b1;
    wait_clk(2);
    for (int i = 9; i >= 0; i--) bit_out(cmd[i], s);
    if (has_data) for (int i = 7; i >= 0; i--) bit_out(data[i], s);
    gap();
  endtask

  task automatic rd(input logic [6:0] a, input int lead0, input bit tail, output logic [7:0] d);
    logic [9:0] cmd;
    logic s;
    cmd = mk(2'b10, a);
    cs = 1'b1;
    wait_clk(2);
    for (int i = 0; i < lead0; i++) bit_out(1'b0, s);
    for (int i = 9; i >= 0; i--) bit_out(cmd[i], s);
    d[7] = s;
    for (int j = 6; j >= 0; j--) begin
      bit_out(1'b0, s);
      d[j] = s;
    end
    if (tail) begin
      bit_out(1'b0, s);
      check8("R2 line high after last bit", {7'd0, s}, 8'd1);
    end
    gap();
  endtask

  task automatic poll(input string tag, input bit exp_busy);
    cs = 1'b1;
    wait_clk(8);
    check8(tag, {7'd0, do_w}, exp_busy ? 8'd0 : 8'd1);
    if (exp_busy) begin
      wait_clk(PROG / 2);
      check8({tag, " mid"}, {7'd0, do_w}, 8'd0);
      wait_clk(PROG / 2 + 60);
      check8({tag, " end"}, {7'd0, do_w}, 8'd1);
    end
    gap();
  endtask

  task automatic enable();  instr(mk(2'b00, 7'h60), 1'b0, 8'h00); endtask
  task automatic disable_w(); instr(mk(2'b00, 7'h00), 1'b0, 8'h00); endtask

  task automatic t_reset();
    check8("R12 reset data out", {7'd0, do_w}, 8'd1);
    cs = 1'b1;
    wait_clk(10);
    check8("R12 idle selected", {7'd0, do_w}, 8'd1);
    gap();
  endtask

  task automatic t_erase_all();
    logic [7:0] d;
    enable();
    instr(mk(2'b00, 7'h40), 1'b0, 8'h00);
    poll("R5 erase-all busy", 1'b1);
    rd(7'h00, 0, 1'b0, d); check8("R8 addr 00", d, 8'hFF);
    rd(7'h55, 0, 1'b0, d); check8("R8 addr 55", d, 8'hFF);
    rd(7'h7F, 0, 1'b0, d); check8("R8 addr 7F", d, 8'hFF);
  endtask

  task automatic t_disable();
    logic [7:0] d;
    disable_w();
    instr(mk(2'b01, 7'h03), 1'b1, 8'h5A);
    poll("R7 no window when disabled", 1'b0);
    rd(7'h03, 0, 1'b0, d); check8("R7 disabled write", d, 8'hFF);
  endtask

  task automatic t_reset_wen();
    logic [7:0] d;
    enable();
    rst = 1'b1;
    wait_clk(4);
    rst = 1'b0;
    wait_clk(4);
    instr(mk(2'b01, 7'h07), 1'b1, 8'h12);
    poll("R6 no window after reset", 1'b0);
    rd(7'h07, 0, 1'b0, d); check8("R6 reset cleared enable", d, 8'hFF);
  endtask

  task automatic t_write_read();
    logic [7:0] d;
    enable();
    instr(mk(2'b01, 7'h10), 1'b1, 8'hA5);
    poll("R5 write busy", 1'b1);
    rd(7'h10, 0, 1'b1, d); check8("R3 R2 write A5", d, 8'hA5);
    instr(mk(2'b01, 7'h7F), 1'b1, 8'h3C);
    poll("R5 write top busy", 1'b1);
    rd(7'h7F, 0, 1'b0, d); check8("R3 top address", d, 8'h3C);
    rd(7'h10, 3, 1'b0, d); check8("R1 leading zeros", d, 8'hA5);
  endtask

  task automatic t_erase();
    logic [7:0] d;
    instr(mk(2'b11, 7'h10), 1'b0, 8'h00);
    poll("R5 erase busy", 1'b1);
    rd(7'h10, 0, 1'b0, d); check8("R4 erase byte", d, 8'hFF);
    rd(7'h7F, 0, 1'b0, d); check8("R4 neighbour kept", d, 8'h3C);
  endtask

  task automatic t_busy_ignore();
    logic [7:0] d;
    instr(mk(2'b01, 7'h20), 1'b1, 8'h11);
    instr(mk(2'b01, 7'h21), 1'b1, 8'h22);
    wait_clk(PROG + 40);
    rd(7'h20, 0, 1'b0, d); check8("R10 first write", d, 8'h11);
    rd(7'h21, 0, 1'b0, d); check8("R10 ignored while busy", d, 8'hFF);
  endtask

  task automatic t_abort();
    logic [7:0] d;
    logic [9:0] cmd;
    logic s;
    cmd = mk(2'b01, 7'h30);
    cs = 1'b1;
    wait_clk(2);
    for (int i = 9; i >= 0; i--) bit_out(cmd[i], s);
    for (int i = 0; i < 4; i++) bit_out(1'b0, s);
    gap();
    poll("R11 no window after abort", 1'b0);
    rd(7'h30, 0, 1'b0, d); check8("R11 aborted write", d, 8'hFF);
  endtask

  task automatic t_write_all();
    logic [7:0] d;
    instr(mk(2'b00, 7'h20), 1'b1, 8'h69);
    poll("R5 write-all busy", 1'b1);
    rd(7'h00, 0, 1'b0, d); check8("R9 addr 00", d, 8'h69);
    rd(7'h40, 0, 1'b0, d); check8("R9 addr 40", d, 8'h69);
    rd(7'h7F, 0, 1'b0, d); check8("R9 addr 7F", d, 8'h69);
  endtask

  initial begin : watchdog
    wait_clk(150000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end

  initial begin : main
    wait_clk(5);
    rst = 1'b0;
    wait_clk(5);
    t_reset();
    t_erase_all();
    t_disable();
    t_reset_wen();
    t_write_read();
    t_erase();
    t_busy_ignore();
    t_abort();
    t_write_all();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
    $finish;
  end
endmodule